// File: doc/BRIEF.md
# Serial Link Transceiver Reset Sequencer

This block brings a serial link transceiver out of reset in a fixed order. One active-low global reset clears everything. When that reset is released, the block first frees the SERDES reset. The transmit digital reset is held until the transmit PLL lock has stayed high for a set number of fabric clock cycles. The receive side follows a reduced link state sequence with three states: quiet detect, active detect and polling. It advances when the receive PLL locks and again when a PHY status strobe reports that a receiver was found. On entering polling, the receive digital reset stays held until signal detect has remained high for a qualification window. That window is several milliseconds on real hardware and is set in cycles by a parameter.

Once both digital resets are free, the block drops an application-level reset status. The logic around the link waits on that status before it starts work.

Top module: `xrs_top`

## Requirements
- R1: While `rst_n` is low, `serdes_rst`, `tx_dig_rst`, `rx_dig_rst` and `app_rst_status` are all high and `link_state` is 0 (quiet detect). This holds at once, without a clock edge, including when `rst_n` falls in the middle of operation.
- R2: `serdes_rst` goes low on the first clock edge at which `rst_n` is sampled high.
- R3: `tx_dig_rst` goes low right after the edge at which `tx_pll_locked` has been sampled high on `TX_LOCK_CYCLES` consecutive edges. After that it stays low until the next global reset, whatever the lock input does.
- R4: If `tx_pll_locked` is sampled low before the transmit window completes, the count restarts from zero.
- R5: In quiet detect (`link_state` 0), an edge with `rx_pll_locked` high moves `link_state` to 1 (active detect). A PHY status strobe in quiet detect has no effect.
- R6: In active detect, an edge with `phy_status` high and `rx_status` equal to 3 moves `link_state` to 2 (polling). A strobe with any other `rx_status` code, or `rx_status` 3 without a strobe, leaves `link_state` at 1.
- R7: `rx_dig_rst` is high from reset through polling entry. It goes low right after the edge at which `rx_sig_det` has been sampled high on `RX_SD_CYCLES` consecutive edges in polling. The count starts with the first edge spent in polling.
- R8: If `rx_sig_det` is sampled low before the receive window completes, the count restarts from zero.
- R9: `app_rst_status` goes low one edge after both `tx_dig_rst` and `rx_dig_rst` are low, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Global reset, active low, asynchronous assert |
| tx_pll_locked | input | 1 | Transmit PLL lock indication |
| rx_pll_locked | input | 1 | Receive PLL lock indication |
| rx_sig_det | input | 1 | Receiver signal-detect |
| phy_status | input | 1 | PHY status completion strobe |
| rx_status | input | 3 | Receiver status code qualified by `phy_status` |
| serdes_rst | output | 1 | Reset to the transceiver SERDES |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| link_state | output | 2 | 0 quiet detect, 1 active detect, 2 polling |
| app_rst_status | output | 1 | Reset status for application logic |

## Verification
The hardest case is a qualification window that nearly finishes. The input drops on the last edges before completion, and the window must then restart and run its full length again. The stimulus first lets each lock or detect input run for part of a window and drops it for exactly one sampled edge. It then counts the full window from that edge and checks the reset one edge before completion and again at the completion edge. Receiver-detect strobes carrying wrong status codes are walked from a vector table while the link is in active detect. A global reset is also applied between clock edges after both resets have been released, to show that the outputs fall back without waiting for an edge.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

   typedef enum logic [1:0] {
      LS_DET_QUIET  = 2'd0,
      LS_DET_ACTIVE = 2'd1,
      LS_POLLING    = 2'd2
   } link_state_e;

endpackage

// File: rtl/xrs_stable_qual.sv
// Counts consecutive high samples of sig while en is high; sets a sticky
// done flag when LIMIT of them have been seen. A low sample restarts.
module xrs_stable_qual #(
   parameter int unsigned LIMIT = 127
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sig,
   output logic done
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("xrs_stable_qual: LIMIT must be at least 1");
      end

      if (LIMIT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done <= 1'b0;
            end else if (en && sig) begin
               done <= 1'b1;
            end
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               done <= 1'b0;
            end else if (done) begin
               cnt <= '0;
            end else if (en && sig) begin
               if (cnt == LAST) begin
                  done <= 1'b1;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               cnt <= '0;
            end
         end

         // R4 R8: a low sample before completion leaves the window empty
         assert_window_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!done && !(en && sig)) |=> (cnt == '0 && !done));

         // R3 R7: done cannot appear while the window is short of its end
         assert_no_early_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!done && cnt != LAST) |=> !done);
      end
   endgenerate

   // R3 R7: release is sticky until the global reset
   assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R3 R7: release only follows a qualifying sample
   assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(en && sig));

endmodule

// File: rtl/xrs_link_fsm.sv
module xrs_link_fsm
   import xrs_pkg::*;
#(
   parameter int unsigned STATUS_W = 3,
   parameter int unsigned DET_CODE = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_pll_locked,
   input  logic                phy_status,
   input  logic [STATUS_W-1:0] rx_status,
   output link_state_e         state
);

   localparam logic [STATUS_W-1:0] DET_VAL = STATUS_W'(DET_CODE);

   generate
      if (DET_CODE >= (1 << STATUS_W)) begin : g_bad_code
         $error("xrs_link_fsm: DET_CODE does not fit in STATUS_W bits");
      end
   endgenerate

   link_state_e nxt;
   logic        det_hit;

   assign det_hit = phy_status && (rx_status == DET_VAL);

   always_comb begin
      nxt = state;
      unique case (state)
         LS_DET_QUIET:  if (rx_pll_locked) nxt = LS_DET_ACTIVE;
         LS_DET_ACTIVE: if (det_hit)       nxt = LS_POLLING;
         LS_POLLING:    nxt = LS_POLLING;
         default:       nxt = LS_DET_QUIET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LS_DET_QUIET;
      else        state <= nxt;
   end

   // R5: quiet detect only moves forward to active detect
   assert_quiet_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_DET_QUIET) |=> (state == LS_DET_QUIET || state == LS_DET_ACTIVE));

   // R6: a strobe with a wrong code keeps active detect
   assert_bad_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_DET_ACTIVE && phy_status && rx_status != DET_VAL) |=> (state == LS_DET_ACTIVE));

   // R6: polling is reached only from a qualified detect strobe
   assert_poll_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) != LS_POLLING && state == LS_POLLING) |->
         ($past(state) == LS_DET_ACTIVE && $past(phy_status) && $past(rx_status) == DET_VAL));

endmodule

// File: rtl/xrs_top.sv
module xrs_top
   import xrs_pkg::*;
#(
   parameter int unsigned TX_LOCK_CYCLES = 127,
   parameter int unsigned RX_SD_CYCLES   = 375000,
   parameter int unsigned STATUS_W       = 3,
   parameter int unsigned DET_CODE       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_pll_locked,
   input  logic                rx_pll_locked,
   input  logic                rx_sig_det,
   input  logic                phy_status,
   input  logic [STATUS_W-1:0] rx_status,
   output logic                serdes_rst,
   output logic                tx_dig_rst,
   output logic                rx_dig_rst,
   output logic [1:0]          link_state,
   output logic                app_rst_status
);

   link_state_e state;
   logic        tx_done;
   logic        rx_done;
   logic        in_poll;

   xrs_link_fsm #(
      .STATUS_W (STATUS_W),
      .DET_CODE (DET_CODE)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_pll_locked (rx_pll_locked),
      .phy_status    (phy_status),
      .rx_status     (rx_status),
      .state         (state)
   );

   xrs_stable_qual #(.LIMIT(TX_LOCK_CYCLES)) u_tx_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .sig   (tx_pll_locked),
      .done  (tx_done)
   );

   assign in_poll = (state == LS_POLLING);

   xrs_stable_qual #(.LIMIT(RX_SD_CYCLES)) u_rx_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_poll),
      .sig   (rx_sig_det),
      .done  (rx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serdes_rst     <= 1'b1;
         app_rst_status <= 1'b1;
      end else begin
         serdes_rst     <= 1'b0;
         app_rst_status <= !(tx_done && rx_done);
      end
   end

   assign tx_dig_rst = !tx_done;
   assign rx_dig_rst = !rx_done;
   assign link_state = state;

   // R1: every reset output held and link state quiet while reset is low
   assert_reset_hold_R1: assert property (@(posedge clk)
      !rst_n |-> (serdes_rst && tx_dig_rst && rx_dig_rst && app_rst_status && link_state == 2'd0));

   // R2: SERDES reset leaves at the first edge out of reset
   assert_serdes_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      serdes_rst |=> !serdes_rst);

   // R3: transmit release needs lock high on the releasing edge
   assert_tx_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_dig_rst) |-> $past(tx_pll_locked));

   // R7: receive release only happens in polling with signal present
   assert_rx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_dig_rst) |-> ($past(state) == LS_POLLING && $past(rx_sig_det)));

   // R9: application status drops only after both digital resets are free
   assert_app_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(app_rst_status) |-> ($past(!tx_dig_rst) && $past(!rx_dig_rst)));

endmodule

// File: tb/xrs_top_bench.sv
module xrs_top_bench;

   localparam int TXN = 16;
   localparam int RXN = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       tx_pll_locked = 1'b0;
   logic       rx_pll_locked = 1'b0;
   logic       rx_sig_det = 1'b0;
   logic       phy_status = 1'b0;
   logic [2:0] rx_status = 3'd0;
   logic       serdes_rst, tx_dig_rst, rx_dig_rst, app_rst_status;
   logic [1:0] link_state;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   xrs_top #(
      .TX_LOCK_CYCLES (TXN),
      .RX_SD_CYCLES   (RXN)
   ) u_xrs_top (
      .clk            (clk),
      .rst_n          (rst_n),
      .tx_pll_locked  (tx_pll_locked),
      .rx_pll_locked  (rx_pll_locked),
      .rx_sig_det     (rx_sig_det),
      .phy_status     (phy_status),
      .rx_status      (rx_status),
      .serdes_rst     (serdes_rst),
      .tx_dig_rst     (tx_dig_rst),
      .rx_dig_rst     (rx_dig_rst),
      .link_state     (link_state),
      .app_rst_status (app_rst_status)
   );

   // fields: rx_pll_locked, phy_status, rx_status[2:0], expected link_state[1:0]
   localparam logic [6:0] VEC [8] = '{
      7'b0_0_000_00,  // R5 no lock: stay quiet
      7'b0_1_011_00,  // R5 strobe in quiet ignored
      7'b1_0_000_01,  // R5 lock: to active detect
      7'b1_1_010_01,  // R6 wrong code 2
      7'b1_1_111_01,  // R6 wrong code 7
      7'b1_0_011_01,  // R6 code 3 without strobe
      7'b1_1_011_10,  // R6 detected: polling
      7'b1_0_000_10   // R6 polling holds
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_all_reset(input string req);
      check({req, " serdes_rst"}, int'(serdes_rst), 1);
      check({req, " tx_dig_rst"}, int'(tx_dig_rst), 1);
      check({req, " rx_dig_rst"}, int'(rx_dig_rst), 1);
      check({req, " app_rst_status"}, int'(app_rst_status), 1);
      check({req, " link_state"}, int'(link_state), 0);
   endtask

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1 rst_n = 1'b0;
      #2 check_all_reset("R1 power-on");
      tick(2);
      check_all_reset("R1 held");

      // release with tx lock present
      rst_n = 1'b1;
      tx_pll_locked = 1'b1;
      tick(1);
      check("R2 serdes_rst released", int'(serdes_rst), 0);
      check("R3 tx_dig_rst held", int'(tx_dig_rst), 1);
      tick(4);
      // R4: one low sample restarts the transmit window
      tx_pll_locked = 1'b0;
      tick(1);
      tx_pll_locked = 1'b1;
      tick(TXN - 1);
      check("R4 tx_dig_rst held after restart", int'(tx_dig_rst), 1);
      tick(1);
      check("R3 tx_dig_rst released", int'(tx_dig_rst), 0);
      check("R9 app status held, rx not free", int'(app_rst_status), 1);
      tx_pll_locked = 1'b0;
      tick(3);
      check("R3 tx release sticky", int'(tx_dig_rst), 0);
      tx_pll_locked = 1'b1;

      // link state table, R5 and R6
      foreach (VEC[i]) begin
         rx_pll_locked = VEC[i][6];
         phy_status    = VEC[i][5];
         rx_status     = VEC[i][4:2];
         tick(1);
         check($sformatf("R5/R6 vector %0d link_state", i), int'(link_state), int'(VEC[i][1:0]));
         phy_status = 1'b0;
      end
      check("R7 rx_dig_rst held in polling", int'(rx_dig_rst), 1);

      // receive window with one dropout, R8 then R7
      rx_sig_det = 1'b1;
      tick(7);
      rx_sig_det = 1'b0;
      tick(1);
      rx_sig_det = 1'b1;
      tick(RXN - 1);
      check("R8 rx_dig_rst held after restart", int'(rx_dig_rst), 1);
      check("R9 app status held", int'(app_rst_status), 1);
      tick(1);
      check("R7 rx_dig_rst released", int'(rx_dig_rst), 0);
      check("R9 app status one edge later", int'(app_rst_status), 1);
      tick(1);
      check("R9 app status released", int'(app_rst_status), 0);
      rx_sig_det = 1'b0;
      tick(2);
      check("R7 rx release sticky", int'(rx_dig_rst), 0);

      // mid-operation reset between edges
      #3 rst_n = 1'b0;
      #1 check_all_reset("R1 mid-run");
      tick(2);
      check_all_reset("R1 mid-run held");
      rst_n = 1'b1;
      tick(1);
      check("R2 serdes_rst released again", int'(serdes_rst), 0);
      check("R5 quiet to active again", int'(link_state), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule